// File: doc/BRIEF.md
# Flash Block Protection Manager

This block keeps the write-protection state for every erase block of a flash array. Each block has a protect bit, which stops program and erase, and a lock bit. When a block's lock bit is set and the write-protect input is driven low, its protect bit is frozen. Protect, unprotect and lock commands arrive with a block number. The block answers two independent lookups: a status query that returns the protect and lock bits of one block, and a permission lookup that reports whether a target block may be programmed or erased.

Power-up reset marks every block protected and clears every lock. A command can fail in two ways. It is dropped if it names a block outside the array. It is refused if the block is locked while write-protect is low. Bus command decoding and the array itself are handled elsewhere. Both lookups are registered, so each answer appears one clock edge after the address is sampled.

Top module: `fbp_guard`

## Requirements
- R1: While `rst_n` is low and after it is released, every block reads protected (status bit 0 = 1) and unlocked (status bit 1 = 0), and `pe_allowed` is 0.
- R2: A command with `cmd_op` = 1 (protect) sets the protect bit of block `cmd_blk`.
- R3: A command with `cmd_op` = 2 (unprotect) clears the protect bit of block `cmd_blk`. Every other block keeps its state.
- R4: A command with `cmd_op` = 3 (lock) sets the lock bit of block `cmd_blk`, whatever the level of `wp_n`, and leaves its protect bit unchanged.
- R5: While `wp_n` is low, protect and unprotect commands to a locked block are refused, and its protect bit keeps its value.
- R6: While `wp_n` is high, lock bits have no effect, and protect and unprotect commands to a locked block are accepted.
- R7: `pe_allowed` is 1 exactly when the protect bit of block `tgt_blk` is clear. It reflects the address and state present at the previous clock edge.
- R8: `qry_status` gives bit 0 = protected and bit 1 = locked for block `qry_blk`. It is loaded at a clock edge and holds between edges.
- R9: A command whose block number is 71 or greater is ignored. A lookup of such a block returns status 2'b01 and `pe_allowed` 0.
- R10: Lock bits are cleared only by `rst_n`. No command clears a lock bit, including unprotect.
- R11: A command with `cmd_op` = 0, or with `cmd_valid` low, changes no block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| cmd_valid | input | 1 | Command strobe, sampled at the rising edge |
| cmd_op | input | 2 | 0 none, 1 protect, 2 unprotect, 3 lock |
| cmd_blk | input | 7 | Block number of the command |
| wp_n | input | 1 | Write-protect input, active low |
| qry_blk | input | 7 | Block number for the status query |
| qry_status | output | 2 | Bit 0 protected, bit 1 locked |
| tgt_blk | input | 7 | Block number for the permission lookup |
| pe_allowed | output | 1 | Program/erase permitted for the target block |

## Verification
A command changes a block's bits at the edge that samples it. A lookup register loads at that same edge from the old bits, so the new state first shows on `qry_status` and `pe_allowed` one edge later. The bench therefore drives each command for one edge, then points both lookups at the block and lets one more edge pass. It samples on the falling edge after that, so every check lands one full register stage behind its stimulus. One directed case moves `qry_blk` between edges and confirms that the old answer holds until the next rising edge.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_PROT   = 2'd1,
      OP_UNPROT = 2'd2,
      OP_LOCK   = 2'd3
   } fbp_op_e;

   localparam logic [1:0] ST_RESET = 2'b01;
endpackage

// File: rtl/fbp_cell.sv
module fbp_cell
   import fbp_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    hit,
   input  fbp_op_e op,
   input  logic    wp_n,
   output logic    prot,
   output logic    lock
);
   logic frozen;
   assign frozen = lock & ~wp_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot <= 1'b1;
         lock <= 1'b0;
      end else if (hit) begin
         unique case (op)
            OP_PROT:   if (!frozen) prot <= 1'b1;
            OP_UNPROT: if (!frozen) prot <= 1'b0;
            OP_LOCK:   lock <= 1'b1;
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/fbp_rdport.sv
module fbp_rdport
   import fbp_pkg::*;
#(
   parameter int NUM_BLOCKS = 71,
   parameter bit REG_OUT    = 1'b1,
   localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_BLOCKS-1:0] prot_vec,
   input  logic [NUM_BLOCKS-1:0] lock_vec,
   input  logic [BLK_W-1:0]      addr,
   output logic [1:0]            stat
);
   localparam logic [BLK_W:0] LIMIT = (BLK_W+1)'(NUM_BLOCKS);

   logic [1:0] stat_c;

   always_comb begin
      if ({1'b0, addr} < LIMIT) stat_c = {lock_vec[addr], prot_vec[addr]};
      else                      stat_c = ST_RESET;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat <= ST_RESET;
            else        stat <= stat_c;
         end
      end else begin : g_comb
         assign stat = stat_c;
      end
   endgenerate
endmodule

// File: rtl/fbp_guard.sv
module fbp_guard
   import fbp_pkg::*;
#(
   parameter int NUM_BLOCKS = 71,
   parameter bit REG_OUT    = 1'b1,
   localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [BLK_W-1:0] cmd_blk,
   input  logic             wp_n,
   input  logic [BLK_W-1:0] qry_blk,
   output logic [1:0]       qry_status,
   input  logic [BLK_W-1:0] tgt_blk,
   output logic             pe_allowed
);
   generate
      if (NUM_BLOCKS < 2 || NUM_BLOCKS > 4096) begin : g_bad_size
         $error("fbp_guard: NUM_BLOCKS must lie in 2..4096");
      end
   endgenerate

   logic [NUM_BLOCKS-1:0] prot_vec;
   logic [NUM_BLOCKS-1:0] lock_vec;
   fbp_op_e               op_e;

   assign op_e = fbp_op_e'(cmd_op);

   generate
      for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
         logic hit;
         assign hit = cmd_valid && (cmd_blk == BLK_W'(i));
         fbp_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .hit  (hit),
            .op   (op_e),
            .wp_n (wp_n),
            .prot (prot_vec[i]),
            .lock (lock_vec[i])
         );
      end
   endgenerate

   fbp_rdport #(.NUM_BLOCKS(NUM_BLOCKS), .REG_OUT(REG_OUT)) u_qry (
      .clk     (clk),
      .rst_n   (rst_n),
      .prot_vec(prot_vec),
      .lock_vec(lock_vec),
      .addr    (qry_blk),
      .stat    (qry_status)
   );

   logic [1:0] tgt_stat;
   logic       tgt_unused_lock;

   fbp_rdport #(.NUM_BLOCKS(NUM_BLOCKS), .REG_OUT(REG_OUT)) u_tgt (
      .clk     (clk),
      .rst_n   (rst_n),
      .prot_vec(prot_vec),
      .lock_vec(lock_vec),
      .addr    (tgt_blk),
      .stat    (tgt_stat)
   );

   assign pe_allowed      = ~tgt_stat[0];
   assign tgt_unused_lock = tgt_stat[1];
endmodule

// File: rtl/fbp_guard_chk.sv
module fbp_guard_chk #(
   parameter int NUM_BLOCKS = 71,
   parameter bit REG_OUT    = 1'b1,
   localparam int BW        = $clog2(NUM_BLOCKS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cmd_valid,
   input logic [1:0]            cmd_op,
   input logic [BW-1:0]         cmd_blk,
   input logic                  wp_n,
   input logic [BW-1:0]         qry_blk,
   input logic [1:0]            qry_status,
   input logic [BW-1:0]         tgt_blk,
   input logic                  pe_allowed,
   input logic [NUM_BLOCKS-1:0] prot_vec,
   input logic [NUM_BLOCKS-1:0] lock_vec
);
   localparam logic [BW:0] LIMIT = (BW+1)'(NUM_BLOCKS);

   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((&prot_vec) && (lock_vec == '0)));

   p_locked_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_n |=> (((prot_vec ^ $past(prot_vec)) & $past(lock_vec)) == '0));

   p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|lock_vec) |=> ((lock_vec & $past(lock_vec)) == $past(lock_vec)));

   p_oob_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && ({1'b0, cmd_blk} >= LIMIT)) |=> ($stable(prot_vec) && $stable(lock_vec)));

   p_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_valid || cmd_op == 2'd0) |=> ($stable(prot_vec) && $stable(lock_vec)));

   generate
      if (REG_OUT) begin : g_reg_chk
         p_oob_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, $past(qry_blk)} >= LIMIT) |-> (qry_status == 2'b01));
         p_pe_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
            pe_allowed |-> ({1'b0, $past(tgt_blk)} < LIMIT));
      end
   endgenerate
endmodule

bind fbp_guard fbp_guard_chk #(.NUM_BLOCKS(NUM_BLOCKS), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/fbp_guard_tb.sv
module fbp_guard_tb;
   localparam int NB = 71;
   localparam int BW = $clog2(NB);

   typedef struct packed {
      logic [1:0] op;
      logic [6:0] blk;
      logic       wp;
      logic [1:0] st;
      logic       pe;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VT [NV] = '{
      '{2'd2, 7'd5,  1'b1, 2'b00, 1'b1, 4'd3},   // R3 unprotect
      '{2'd1, 7'd5,  1'b1, 2'b01, 1'b0, 4'd2},   // R2 protect
      '{2'd2, 7'd70, 1'b1, 2'b00, 1'b1, 4'd3},   // R3 top block
      '{2'd2, 7'd0,  1'b1, 2'b00, 1'b1, 4'd3},   // R3 bottom block
      '{2'd3, 7'd0,  1'b1, 2'b10, 1'b1, 4'd4},   // R4 lock
      '{2'd1, 7'd0,  1'b0, 2'b10, 1'b1, 4'd5},   // R5 refused protect
      '{2'd1, 7'd0,  1'b1, 2'b11, 1'b0, 4'd6},   // R6 accepted protect
      '{2'd2, 7'd0,  1'b0, 2'b11, 1'b0, 4'd5},   // R5 refused unprotect
      '{2'd2, 7'd0,  1'b1, 2'b10, 1'b1, 4'd10},  // R10 R6 lock survives
      '{2'd0, 7'd70, 1'b1, 2'b00, 1'b1, 4'd11},  // R11 no-op
      '{2'd1, 7'd71, 1'b1, 2'b01, 1'b0, 4'd9},   // R9 out of range
      '{2'd3, 7'd3,  1'b0, 2'b11, 1'b0, 4'd4}    // R4 lock with wp low
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'd0;
   logic [BW-1:0] cmd_blk = '0;
   logic          wp_n = 1'b1;
   logic [BW-1:0] qry_blk = '0;
   logic [1:0]    qry_status;
   logic [BW-1:0] tgt_blk = '0;
   logic          pe_allowed;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   always #5 clk = ~clk;

   fbp_guard u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_blk(cmd_blk), .wp_n(wp_n), .qry_blk(qry_blk),
      .qry_status(qry_status), .tgt_blk(tgt_blk), .pe_allowed(pe_allowed)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string rq, input logic [1:0] act, input logic [1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", rq, act, exp);
      end
   endtask

   task automatic look(input logic [BW-1:0] b);
      qry_blk = b;
      tgt_blk = b;
      tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      chk("R1 status in reset", qry_status, 2'b01);
      chk("R1 pe in reset", {1'b0, pe_allowed}, 2'b00);
      rst_n = 1'b1;
      tick();
      foreach (VT[k]) begin end
      for (int b = 0; b < NB; b += 35) begin
         look(BW'(b));
         chk("R1 status after reset", qry_status, 2'b01);
         chk("R1 pe after reset", {1'b0, pe_allowed}, 2'b00);
      end

      for (int i = 0; i < NV; i++) begin
         cmd_valid = 1'b1;
         cmd_op    = VT[i].op;
         cmd_blk   = VT[i].blk;
         wp_n      = VT[i].wp;
         tick();
         cmd_valid = 1'b0;
         look(VT[i].blk);
         chk($sformatf("R%0d table[%0d] status", VT[i].rq, i), qry_status, VT[i].st);
         chk($sformatf("R%0d table[%0d] pe", VT[i].rq, i), {1'b0, pe_allowed}, {1'b0, VT[i].pe});
         if (i == 0) begin
            look(BW'(6));
            chk("R3 neighbour untouched", qry_status, 2'b01);
         end
      end

      // R8: answer holds between edges, updates at the edge
      wp_n = 1'b1;
      look(BW'(0));
      chk("R8 status block 0", qry_status, 2'b10);
      qry_blk = BW'(70);
      #1;
      chk("R8 holds before edge", qry_status, 2'b10);
      tick();
      chk("R8 updates after edge", qry_status, 2'b00);

      // R7: independent target lookup
      qry_blk = BW'(3);
      tgt_blk = BW'(70);
      tick();
      chk("R7 pe on clear block", {1'b0, pe_allowed}, 2'b01);
      chk("R8 query on other block", qry_status, 2'b11);

      // R1 R10: only reset clears locks
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      look(BW'(0));
      chk("R1 R10 lock cleared by reset", qry_status, 2'b01);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule